// File: doc/BRIEF.md
# Instrumented Atomic Spin-Lock Bank

A bank of hardware lock words shared by up to six requesting processors. Each requester presents a lock index together with one of two operations. A probe only reads the lock state and never takes the shared path. An atomic claim reads the lock and, if it is free, marks it taken in the same indivisible operation. A round-robin arbiter admits at most one operation per cycle. A claim occupies a second cycle, the write phase. During that cycle no requester is granted, and an I/O channel that asks for the shared path is stalled.

Every lock keeps the identity of the requester that holds it, a count of successful claims and a count of failed claims (spins). Both counters saturate, and one strobe clears all of them. A separate release port frees a lock only when the releasing ID matches the recorded holder. A mismatched release, or a release of a free lock, changes nothing and raises an error pulse. A statistics port reads the held flag, the holder and both counters of any lock combinationally.

Top module: `spin_lock_bank`

## Requirements
- R1: A granted probe returns one cycle after grant. `resp_valid_o` is one-hot on the requester, and `resp_free_o` is 1 exactly when the lock is not held. The lock state and counters stay unchanged.
- R2: A granted claim on a free lock returns two cycles after grant with `resp_free_o`=1. From that cycle the lock is held, its holder is the requester number, and its claim counter has risen by one.
- R3: A granted claim on a held lock returns two cycles after grant with `resp_free_o`=0. Held flag and holder are unchanged, and the spin counter rises by one.
- R4: In the cycle after a claim is granted (the write phase), `grant_o` is all zero whatever is requested, and `io_stall_o` equals `io_req_i`. Outside a write phase, `io_stall_o` is 0.
- R5: At most one grant per cycle. The winner is the first requesting index after the last grantee, counting upward and wrapping. After reset, index 0 has first priority.
- R6: A release whose ID equals the holder of a held lock clears that lock from the next cycle on, and `rel_err_o` stays 0.
- R7: A release from a non-holder, or of a free lock, leaves held flag and holder unchanged. It pulses `rel_err_o` high in the next cycle.
- R8: Claim and spin counters stop at 2^CNT_W-1 and do not wrap.
- R9: `stat_clr_i` zeroes both counters of every lock in the next cycle, and wins over an increment in the same cycle.
- R10: After reset, no lock is held, holders and counters are zero, and `grant_o`, `resp_valid_o`, `rel_err_o` and `io_stall_o` are 0.
- R11: Requester r places its lock index in `req_lock_i[r*LOCK_W +: LOCK_W]`, and `req_op_i[r]`=1 selects a claim while 0 selects a probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request per requester, held until granted |
| req_op_i | input | N_REQ | 1 = atomic claim, 0 = probe |
| req_lock_i | input | N_REQ*LOCK_W | Lock index per requester |
| grant_o | output | N_REQ | One-hot grant, combinational |
| resp_valid_o | output | N_REQ | One-hot response strobe |
| resp_free_o | output | 1 | Lock was free when read |
| io_req_i | input | 1 | I/O channel asks for the shared path |
| io_stall_o | output | 1 | I/O channel held off |
| rel_valid_i | input | 1 | Release strobe |
| rel_id_i | input | ID_W | Releasing requester |
| rel_lock_i | input | LOCK_W | Lock to release |
| rel_err_o | output | 1 | Bad release pulse |
| stat_clr_i | input | 1 | Clear all counters |
| stat_lock_i | input | LOCK_W | Lock selected for statistics |
| stat_held_o | output | 1 | Selected lock is held |
| stat_owner_o | output | ID_W | Holder of selected lock |
| stat_acq_o | output | CNT_W | Claim count of selected lock |
| stat_spin_o | output | CNT_W | Spin count of selected lock |

## Verification
Grant is combinational, so the bench samples it just after driving a request. A probe answers one edge later. A claim answers two edges later, and the write phase in between is where the bench probes `grant_o` and `io_stall_o` while a competing request and an I/O request are raised. Release errors and counter clears land one edge after the strobe. The statistics port is read a little after that edge, once the bench has dropped every strobe.

// File: rtl/slk_pkg.sv
package slk_pkg;
  typedef enum logic {
    OP_PROBE = 1'b0,
    OP_CLAIM = 1'b1
  } slk_op_e;
endpackage

// File: rtl/slk_sat_cnt.sv
module slk_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxVal = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != MaxVal)  cnt_o <= cnt_o + 1'b1;
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MaxVal && !clr_i) |=> cnt_o == MaxVal);
  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));
  // R9
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/slk_rr_arb.sv
module slk_rr_arb #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;

  // search starts one past the last grantee
  always_comb begin
    gnt_o = '0;
    ptr_d = ptr_q;
    for (int k = 1; k <= N; k++) begin
      if (en_i && gnt_o == '0 && req_i[(int'(ptr_q) + k) % N]) begin
        gnt_o[(int'(ptr_q) + k) % N] = 1'b1;
        ptr_d = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= IW'(N - 1);
    else if (|gnt_o)  ptr_q <= ptr_d;
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R5
  gnt_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/slk_lock_entry.sv
module slk_lock_entry #(
  parameter int ID_W  = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             spin_i,
  input  logic             rel_i,
  input  logic             clr_i,
  input  logic [ID_W-1:0]  owner_i,
  output logic             held_o,
  output logic [ID_W-1:0]  owner_o,
  output logic [CNT_W-1:0] acq_o,
  output logic [CNT_W-1:0] spin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o  <= 1'b0;
      owner_o <= '0;
    end else if (set_i) begin
      held_o  <= 1'b1;
      owner_o <= owner_i;
    end else if (rel_i) begin
      held_o  <= 1'b0;
    end
  end

  slk_sat_cnt #(.W(CNT_W)) u_acq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .inc_i(set_i), .cnt_o(acq_o)
  );
  slk_sat_cnt #(.W(CNT_W)) u_spin (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .inc_i(spin_i), .cnt_o(spin_o)
  );

  // R6
  rel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> !held_o);
  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !rel_i) |=> (held_o && $stable(owner_o)));
  // R2
  set_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (held_o && owner_o == $past(owner_i)));
endmodule

// File: rtl/spin_lock_bank.sv
module spin_lock_bank
  import slk_pkg::*;
#(
  parameter int N_REQ  = 6,
  parameter int N_LOCK = 8,
  parameter int CNT_W  = 16,
  parameter int LOCK_W = (N_LOCK > 1) ? $clog2(N_LOCK) : 1,
  parameter int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        req_valid_i,
  input  logic [N_REQ-1:0]        req_op_i,
  input  logic [N_REQ*LOCK_W-1:0] req_lock_i,
  output logic [N_REQ-1:0]        grant_o,
  output logic [N_REQ-1:0]        resp_valid_o,
  output logic                    resp_free_o,
  input  logic                    io_req_i,
  output logic                    io_stall_o,
  input  logic                    rel_valid_i,
  input  logic [ID_W-1:0]         rel_id_i,
  input  logic [LOCK_W-1:0]       rel_lock_i,
  output logic                    rel_err_o,
  input  logic                    stat_clr_i,
  input  logic [LOCK_W-1:0]       stat_lock_i,
  output logic                    stat_held_o,
  output logic [ID_W-1:0]         stat_owner_o,
  output logic [CNT_W-1:0]        stat_acq_o,
  output logic [CNT_W-1:0]        stat_spin_o
);
  // N_LOCK is expected to be a power of two
  logic [N_LOCK-1:0] lock_held;
  logic [ID_W-1:0]   owner_a [N_LOCK];
  logic [CNT_W-1:0]  acq_a   [N_LOCK];
  logic [CNT_W-1:0]  spin_a  [N_LOCK];

  logic              atomic_q, at_free_q;
  logic [ID_W-1:0]   at_id_q;
  logic [LOCK_W-1:0] at_lock_q;

  logic              g_any;
  logic [ID_W-1:0]   g_id;
  slk_op_e           g_op;
  logic [LOCK_W-1:0] g_lock;
  logic              rel_ok;

  slk_rr_arb #(.N(N_REQ)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(!atomic_q),
    .req_i(req_valid_i), .gnt_o(grant_o)
  );

  always_comb begin
    g_any  = |grant_o;
    g_id   = '0;
    g_op   = OP_PROBE;
    g_lock = '0;
    for (int r = 0; r < N_REQ; r++) begin
      if (grant_o[r]) begin
        g_id   = ID_W'(r);
        g_op   = slk_op_e'(req_op_i[r]);
        g_lock = req_lock_i[r*LOCK_W +: LOCK_W];
      end
    end
  end

  assign rel_ok = rel_valid_i && lock_held[rel_lock_i] && owner_a[rel_lock_i] == rel_id_i;

  // claim: read phase at grant edge, write phase one cycle later with path held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      atomic_q     <= 1'b0;
      at_free_q    <= 1'b0;
      at_id_q      <= '0;
      at_lock_q    <= '0;
      resp_valid_o <= '0;
      resp_free_o  <= 1'b0;
      rel_err_o    <= 1'b0;
    end else begin
      atomic_q     <= g_any && g_op == OP_CLAIM;
      resp_valid_o <= '0;
      rel_err_o    <= rel_valid_i && !rel_ok;
      if (g_any && g_op == OP_CLAIM) begin
        at_free_q <= !lock_held[g_lock];
        at_id_q   <= g_id;
        at_lock_q <= g_lock;
      end
      if (g_any && g_op == OP_PROBE) begin
        resp_valid_o <= grant_o;
        resp_free_o  <= !lock_held[g_lock];
      end
      if (atomic_q) begin
        resp_valid_o          <= '0;
        resp_valid_o[at_id_q] <= 1'b1;
        resp_free_o           <= at_free_q;
      end
    end
  end

  assign io_stall_o = io_req_i && atomic_q;

  for (genvar l = 0; l < N_LOCK; l++) begin : g_lock_e
    slk_lock_entry #(.ID_W(ID_W), .CNT_W(CNT_W)) u_entry (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (atomic_q && at_free_q && at_lock_q == LOCK_W'(l)),
      .spin_i (atomic_q && !at_free_q && at_lock_q == LOCK_W'(l)),
      .rel_i  (rel_ok && rel_lock_i == LOCK_W'(l)),
      .clr_i  (stat_clr_i),
      .owner_i(at_id_q),
      .held_o (lock_held[l]),
      .owner_o(owner_a[l]),
      .acq_o  (acq_a[l]),
      .spin_o (spin_a[l])
    );
  end

  assign stat_held_o  = lock_held[stat_lock_i];
  assign stat_owner_o = owner_a[stat_lock_i];
  assign stat_acq_o   = acq_a[stat_lock_i];
  assign stat_spin_o  = spin_a[stat_lock_i];

  // R4
  atomic_nogrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_any && g_op == OP_CLAIM) |=> grant_o == '0);
  // R4
  atomic_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_any && g_op == OP_CLAIM) |=> io_stall_o == io_req_i);
  // R1
  probe_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_any && g_op == OP_PROBE) |=> resp_valid_o == $past(grant_o));
  // R2
  claim_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atomic_q |=> $onehot(resp_valid_o));
  // R7
  free_rel_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_i && !lock_held[rel_lock_i]) |=> rel_err_o);
endmodule

// File: tb/spin_lock_bank_bench.sv
`timescale 1ns/1ps
module spin_lock_bank_bench;
  localparam int NR = 6, NL = 4, LW = 2, IW = 3, CW = 3;
  localparam int CMAX = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NR-1:0] req_valid_i = '0, req_op_i = '0;
  logic [NR*LW-1:0] req_lock_i = '0;
  logic [NR-1:0] grant_o, resp_valid_o;
  logic resp_free_o, io_req_i = 1'b0, io_stall_o;
  logic rel_valid_i = 1'b0;
  logic [IW-1:0] rel_id_i = '0;
  logic [LW-1:0] rel_lock_i = '0, stat_lock_i = '0;
  logic rel_err_o, stat_clr_i = 1'b0, stat_held_o;
  logic [IW-1:0] stat_owner_o;
  logic [CW-1:0] stat_acq_o, stat_spin_o;

  always #2.5 clk_i = ~clk_i;

  spin_lock_bank #(.N_REQ(NR), .N_LOCK(NL), .CNT_W(CW)) u_spin_lock_bank (.*);

  int vec = 0, bad = 0;
  bit done = 0;
  int m_held[NL], m_owner[NL], m_acq[NL], m_spin[NL];
  int m_ptr = NR - 1;

  task automatic chk(string tag, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic int rr_pick(int mask, int ptr);
    for (int k = 1; k <= NR; k++)
      if (mask[(ptr + k) % NR]) return (ptr + k) % NR;
    return -1;
  endfunction

  task automatic stat(int l, string tag);
    stat_lock_i = LW'(l);
    #0.5;
    chk({tag, " held"}, int'(stat_held_o), m_held[l]);
    if (m_held[l] != 0) chk({tag, " owner"}, int'(stat_owner_o), m_owner[l]);
    chk({tag, " acq"}, int'(stat_acq_o), m_acq[l]);
    chk({tag, " spin"}, int'(stat_spin_o), m_spin[l]);
  endtask

  // one operation by a lone requester; clr_mid pulses the clear in the write phase
  task automatic do_op(int r, bit claim, int l, bit clr_mid, string tag);
    int expf;
    int other;
    other = (r + 1) % NR;
    @(negedge clk_i);
    req_valid_i[r] = 1'b1;
    req_op_i[r] = claim;
    req_lock_i[r*LW +: LW] = LW'(l);
    #0.5;
    chk({tag, " grant (R11)"}, int'(grant_o), 1 << r);
    expf = (m_held[l] == 0) ? 1 : 0;
    m_ptr = r;
    @(negedge clk_i);
    req_valid_i[r] = 1'b0;
    if (!claim) begin
      #0.5;
      chk({tag, " R1 resp_valid"}, int'(resp_valid_o), 1 << r);
      chk({tag, " R1 resp_free"}, int'(resp_free_o), expf);
    end else begin
      io_req_i = 1'b1;
      req_valid_i[other] = 1'b1;
      req_op_i[other] = 1'b0;
      if (clr_mid) stat_clr_i = 1'b1;
      #0.5;
      chk("R4 write-phase grant", int'(grant_o), 0);
      chk("R4 write-phase io_stall", int'(io_stall_o), 1);
      @(negedge clk_i);
      io_req_i = 1'b0;
      req_valid_i[other] = 1'b0;
      stat_clr_i = 1'b0;
      #0.5;
      chk({tag, " claim resp_valid"}, int'(resp_valid_o), 1 << r);
      chk({tag, " claim resp_free"}, int'(resp_free_o), expf);
      if (expf != 0) begin
        m_held[l] = 1; m_owner[l] = r; m_acq[l] = sat(m_acq[l]);
      end else begin
        m_spin[l] = sat(m_spin[l]);
      end
      if (clr_mid) begin
        for (int i = 0; i < NL; i++) begin m_acq[i] = 0; m_spin[i] = 0; end
      end
    end
    stat(l, tag);
  endtask

  task automatic do_rel(int id, int l, string tag);
    int ok;
    @(negedge clk_i);
    rel_valid_i = 1'b1; rel_id_i = IW'(id); rel_lock_i = LW'(l);
    ok = (m_held[l] != 0 && m_owner[l] == id) ? 1 : 0;
    @(negedge clk_i);
    rel_valid_i = 1'b0;
    #0.5;
    chk({tag, " rel_err"}, int'(rel_err_o), 1 - ok);
    if (ok != 0) m_held[l] = 0;
    stat(l, tag);
  endtask

  initial begin
    #500000;
    if (!done) begin
      bad++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51ab));
    for (int i = 0; i < NL; i++) begin m_held[i] = 0; m_owner[i] = 0; m_acq[i] = 0; m_spin[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 grant", int'(grant_o), 0);
    chk("R10 resp_valid", int'(resp_valid_o), 0);
    chk("R10 rel_err", int'(rel_err_o), 0);
    io_req_i = 1'b1; #0.5;
    chk("R4 idle io_stall", int'(io_stall_o), 0);
    io_req_i = 1'b0;
    for (int l = 0; l < NL; l++) stat(l, "R10 reset");

    // directed corners
    do_op(2, 1'b0, 1, 1'b0, "R1 probe free");
    do_op(5, 1'b1, 3, 1'b0, "R2 claim free");
    do_op(1, 1'b1, 3, 1'b0, "R3 claim held");
    do_op(0, 1'b0, 3, 1'b0, "R1 probe held");
    do_rel(1, 3, "R7 non-holder");
    do_rel(4, 0, "R7 free lock");
    do_rel(5, 3, "R6 holder");
    do_op(3, 1'b1, 2, 1'b0, "R2 claim again");
    for (int i = 0; i < 9; i++) do_op(i % NR, 1'b1, 2, 1'b0, "R8 spin saturate");
    do_op(4, 1'b1, 2, 1'b1, "R9 clear beats increment");

    // rotation with all requesters probing
    @(negedge clk_i);
    req_valid_i = '1; req_op_i = '0; req_lock_i = '0;
    for (int c = 0; c < 2 * NR; c++) begin
      int e;
      #0.5;
      e = rr_pick(6'h3f, m_ptr);
      chk("R5 full rotation", int'(grant_o), 1 << e);
      m_ptr = e;
      @(negedge clk_i);
    end
    req_valid_i = '0;

    // random masks of probes
    for (int it = 0; it < 60; it++) begin
      int mask, e;
      mask = int'($urandom_range(1, 63));
      @(negedge clk_i);
      req_valid_i = NR'(mask); req_op_i = '0;
      #0.5;
      e = rr_pick(mask, m_ptr);
      chk("R5 random mask", int'(grant_o), 1 << e);
      m_ptr = e;
      @(negedge clk_i);
      req_valid_i = '0;
      #0.5;
      chk("R1 resp after mask", int'(resp_valid_o), 1 << e);
    end

    // random operation mix
    for (int it = 0; it < 400; it++) begin
      int kind, r, l;
      kind = int'($urandom_range(0, 9));
      r = int'($urandom_range(0, NR - 1));
      l = int'($urandom_range(0, NL - 1));
      if (kind < 3) do_op(r, 1'b0, l, 1'b0, "R1 random probe");
      else if (kind < 7) do_op(r, 1'b1, l, 1'b0, "R2 R3 random claim");
      else if (kind < 9) begin
        if ($urandom_range(0, 1) == 1 && m_held[l] != 0) r = m_owner[l];
        do_rel(r, l, "R6 R7 random release");
      end else begin
        @(negedge clk_i);
        stat_clr_i = 1'b1;
        @(negedge clk_i);
        stat_clr_i = 1'b0;
        for (int i = 0; i < NL; i++) begin m_acq[i] = 0; m_spin[i] = 0; end
        for (int i = 0; i < NL; i++) stat(i, "R9 random clear");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule